// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block decides when a DDR SDRAM controller owes the device an auto-refresh. A free-running interval timer divides the controller clock down to the average refresh period. Each time the timer wraps, one more refresh becomes owed. The command arbiter sees a normal request while refreshes are owed and the banks are precharged. It sees an urgent request once the owed count hits its ceiling of eight. When the arbiter acknowledges that it issued an auto-refresh, the owed count drops by one. The block then holds a busy window covering the refresh cycle time, during which no other command may go to the device.

Owed refreshes may be postponed and later drained as a burst, so the arbiter can put traffic first until urgency forces a refresh. The block also handles entry to and exit from self-refresh. Entry is accepted only with all banks idle and no window running. While self-refresh is active the timer stands still. Exit restarts the owed count and the timer from zero. After exit, a short busy window blocks all commands and a much longer window blocks reads.

Top module: `refresh_sched`

## Requirements
- R1: In reset and on the first cycle after it, ref_req, ref_urgent, ref_busy, rd_block, sr_active and ack_err are all low.
- R2: Outside self-refresh, one refresh becomes owed every REF_PERIOD_CYC cycles. The first one is owed after exactly REF_PERIOD_CYC clock edges from reset release, or from self-refresh exit.
- R3: ref_req is high exactly when the owed count is nonzero, banks_idle is high, ref_busy is low and sr_active is low.
- R4: ref_urgent is high exactly when the owed count equals OWED_MAX (8), whatever banks_idle is. The owed count never exceeds OWED_MAX.
- R5: A ref_ack while the owed count is nonzero lowers the count by one. If a timer wrap falls in the same cycle, the count stays unchanged.
- R6: An accepted ref_ack makes ref_busy high for exactly TRFC_CYC cycles, starting on the next cycle.
- R7: A ref_ack while nothing is owed changes neither the count nor ref_busy. It sets ack_err, which stays high until reset.
- R8: sr_enter_req is accepted only when banks_idle is high, ref_busy is low and sr_active is low. An accepted entry sets sr_active on the next cycle and clears the owed count.
- R9: While sr_active is high, no refresh becomes owed, so ref_req and ref_urgent stay low.
- R10: sr_exit_req while sr_active is high clears sr_active on the next cycle and restarts the owed count and the timer from zero. It holds ref_busy high for TXSNR_CYC cycles and rd_block high for TXSRD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks are precharged |
| ref_ack | input | 1 | Arbiter issued an auto-refresh this cycle |
| sr_enter_req | input | 1 | Request to enter self-refresh |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Normal refresh request |
| ref_urgent | output | 1 | Owed count at its ceiling |
| ref_busy | output | 1 | No command may be issued |
| rd_block | output | 1 | No read may be issued after self-refresh exit |
| sr_active | output | 1 | Self-refresh in effect |
| ack_err | output | 1 | Sticky: acknowledge with nothing owed |

## Verification
The hardest case to reach is a timer wrap that coincides with an accepted acknowledge. Both events depend on the timer phase, and the ports do not show that phase. The stimulus uses self-refresh exit to restart the timer at a known phase. It then counts clock edges so that the acknowledge lands on the second wrap after exit. The cycle-level model in the bench confirms that the owed count neither rises nor falls.

// File: rtl/refs_pkg.sv
package refs_pkg;

  // Next owed count: the acknowledge is taken first, then the wrap is
  // added, so a full count that sees both stays full.
  function automatic int owed_step(int cur, logic add, logic sub, int cap);
    int n;
    n = cur;
    if (sub && n > 0) n = n - 1;
    if (add && n < cap) n = n + 1;
    return n;
  endfunction

  // Width needed to hold values 0..v.
  function automatic int span_bits(int v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int PERIOD = 1300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = refs_pkg::span_bits(PERIOD - 1);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt <= '0;
    else if (run_i) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick_o = run_i && (cnt == LAST);

  // R9
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> run_i);

  generate
    if (PERIOD > 1) begin : g_gap
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ref_owed_ctr.sv
module ref_owed_ctr #(
  parameter int CAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic nonzero_o,
  output logic full_o
);
  localparam int W = refs_pkg::span_bits(CAP);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) count <= '0;
    else count <= W'(refs_pkg::owed_step(int'(count), inc_i, dec_i, CAP));
  end

  assign nonzero_o = (count != '0);
  assign full_o    = (count == W'(CAP));

  // R4
  owed_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= CAP);
  // R8
  owed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !nonzero_o);
  // R5
  owed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i && !clr_i) |=> $stable(count));
endmodule

// File: rtl/ref_window.sv
module ref_window #(
  parameter int LEN = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic active_o
);
  localparam int W = refs_pkg::span_bits(LEN);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load_i) cnt <= W'(LEN);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active_o = (cnt != '0);

  // R6
  window_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !active_o) |=> !active_o);

  generate
    if (LEN > 0) begin : g_open
      // R6
      window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> active_o);
    end
  endgenerate
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int REF_PERIOD_CYC = 1300,
  parameter int OWED_MAX       = 8,
  parameter int TRFC_CYC       = 13,
  parameter int TXSNR_CYC      = 13,
  parameter int TXSRD_CYC      = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic ref_ack,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  output logic ref_req,
  output logic ref_urgent,
  output logic ref_busy,
  output logic rd_block,
  output logic sr_active,
  output logic ack_err
);
  logic sr_q, err_q;
  logic owed_nz, owed_full, tick;
  logic ack_ok, ack_bad, sr_enter_ok, sr_exit_ok, restart;
  logic trfc_on, txsnr_on;

  assign ack_ok      = ref_ack && owed_nz;
  assign ack_bad     = ref_ack && !owed_nz;
  assign sr_enter_ok = sr_enter_req && banks_idle && !ref_busy && !sr_q;
  assign sr_exit_ok  = sr_exit_req && sr_q;
  assign restart     = sr_enter_ok || sr_exit_ok;

  ref_interval_timer #(.PERIOD(REF_PERIOD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(!sr_q), .clr_i(restart), .tick_o(tick)
  );

  ref_owed_ctr #(.CAP(OWED_MAX)) u_owed (
    .clk(clk), .rst_n(rst_n), .clr_i(restart), .inc_i(tick), .dec_i(ack_ok),
    .nonzero_o(owed_nz), .full_o(owed_full)
  );

  ref_window #(.LEN(TRFC_CYC)) u_trfc (
    .clk(clk), .rst_n(rst_n), .load_i(ack_ok), .active_o(trfc_on)
  );

  ref_window #(.LEN(TXSNR_CYC)) u_txsnr (
    .clk(clk), .rst_n(rst_n), .load_i(sr_exit_ok), .active_o(txsnr_on)
  );

  ref_window #(.LEN(TXSRD_CYC)) u_txsrd (
    .clk(clk), .rst_n(rst_n), .load_i(sr_exit_ok), .active_o(rd_block)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (sr_enter_ok) sr_q <= 1'b1;
      else if (sr_exit_ok) sr_q <= 1'b0;
      if (ack_bad) err_q <= 1'b1;
    end
  end

  assign ref_busy   = trfc_on || txsnr_on;
  assign ref_req    = owed_nz && banks_idle && !ref_busy && !sr_q;
  assign ref_urgent = owed_full;
  assign sr_active  = sr_q;
  assign ack_err    = err_q;

  // R3
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (banks_idle && !ref_busy && !sr_active));
  // R9
  urgent_quiet_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !ref_urgent);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bad || ack_err) |=> ack_err);
  // R8
  sr_entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_active) |-> ($past(banks_idle) && !$past(ref_busy)));
  // R10
  sr_exit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_ok |=> (!sr_active && ref_busy && rd_block));
  // R6
  ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> ref_busy);
endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
  localparam int CLK_PER = 10;
  localparam int N      = 20;
  localparam int CAP    = 8;
  localparam int TRFC   = 5;
  localparam int TXSNR  = 4;
  localparam int TXSRD  = 30;

  logic clk = 1'b0;
  logic rst_n, banks_idle, ref_ack, sr_enter_req, sr_exit_req;
  logic ref_req, ref_urgent, ref_busy, rd_block, sr_active, ack_err;
  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PER/2) clk = ~clk;

  refresh_sched #(.REF_PERIOD_CYC(N), .OWED_MAX(CAP), .TRFC_CYC(TRFC),
                  .TXSNR_CYC(TXSNR), .TXSRD_CYC(TXSRD)) u0 (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_ack(ref_ack),
    .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_busy(ref_busy),
    .rd_block(rd_block), .sr_active(sr_active), .ack_err(ack_err)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, written from the requirements.
  int m_tick, m_owed, m_trfc, m_snr, m_rd;
  bit m_sr, m_err;
  wire m_busy = (m_trfc > 0) || (m_snr > 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick <= 0; m_owed <= 0; m_trfc <= 0; m_snr <= 0; m_rd <= 0;
      m_sr <= 0; m_err <= 0;
    end else begin
      bit wrap, took, ent, ext;
      wrap = !m_sr && (m_tick == N - 1);
      took = ref_ack && (m_owed > 0);
      ent  = sr_enter_req && banks_idle && !m_busy && !m_sr;
      ext  = sr_exit_req && m_sr;
      if (ref_ack && m_owed == 0) m_err <= 1;
      m_trfc <= took ? TRFC : (m_trfc > 0 ? m_trfc - 1 : 0);
      m_snr  <= ext ? TXSNR : (m_snr > 0 ? m_snr - 1 : 0);
      m_rd   <= ext ? TXSRD : (m_rd > 0 ? m_rd - 1 : 0);
      if (ent || ext) begin
        m_owed <= 0; m_tick <= 0; m_sr <= ent;
      end else begin
        if (!m_sr) m_tick <= wrap ? 0 : m_tick + 1;
        if (took && !wrap) m_owed <= m_owed - 1;
        else if (wrap && !took && m_owed < CAP) m_owed <= m_owed + 1;
      end
    end
  end

  // Every-cycle comparison, a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rst_n) begin
      chk("R3 ref_req", ref_req, (m_owed > 0) && banks_idle && !m_busy && !m_sr);
      chk("R4 ref_urgent", ref_urgent, m_owed == CAP);
      chk("R6 ref_busy", ref_busy, m_busy);
      chk("R10 rd_block", rd_block, m_rd > 0);
      chk("R8 sr_active", sr_active, m_sr);
      chk("R7 ack_err", ack_err, m_err);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulse_ack();
    ref_ack = 1; @(negedge clk); ref_ack = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; banks_idle = 1; ref_ack = 0; sr_enter_req = 0; sr_exit_req = 0;
    repeat (3) @(negedge clk);
    chk("R1 req", ref_req, 0); chk("R1 urgent", ref_urgent, 0);
    chk("R1 busy", ref_busy, 0); chk("R1 rd_block", rd_block, 0);
    chk("R1 sr", sr_active, 0); chk("R1 err", ack_err, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req after release", ref_req, 0);
    chk("R1 busy after release", ref_busy, 0);
  endtask

  task automatic t_first_tick();
    repeat (18) @(negedge clk);
    chk("R2 no request before period", ref_req, 0);
    @(negedge clk);
    chk("R2 request after period", ref_req, 1);
  endtask

  task automatic t_ack_window();
    int n = 0;
    pulse_ack();
    chk("R5 request cleared", ref_req, 0);
    while (ref_busy && n < 50) begin n++; @(negedge clk); end
    chk("R6 busy length", n, TRFC);
    chk("R5 nothing owed", ref_req, 0);
  endtask

  task automatic t_bad_ack();
    pulse_ack();
    chk("R7 err set", ack_err, 1);
    chk("R7 no busy", ref_busy, 0);
    chk("R7 no request", ref_req, 0);
    repeat (3) @(negedge clk);
    chk("R7 err sticky", ack_err, 1);
  endtask

  task automatic t_urgent_burst();
    banks_idle = 0;
    repeat (170) @(negedge clk);
    chk("R4 urgent at ceiling", ref_urgent, 1);
    chk("R3 held off by busy banks", ref_req, 0);
    repeat (60) @(negedge clk);
    chk("R4 saturated", ref_urgent, 1);
    banks_idle = 1;
    @(negedge clk);
    chk("R3 request with idle banks", ref_req, 1);
    pulse_ack();
    chk("R4 urgent drops", ref_urgent, 0);
    for (int i = 0; i < 150; i++) begin
      if (ref_req) pulse_ack(); else @(negedge clk);
    end
  endtask

  task automatic t_self_refresh();
    int nb = 0, nr = 0;
    while (ref_busy) @(negedge clk);
    banks_idle = 0; sr_enter_req = 1; @(negedge clk); sr_enter_req = 0;
    chk("R8 entry refused", sr_active, 0);
    while (ref_busy) @(negedge clk);
    banks_idle = 1; sr_enter_req = 1; @(negedge clk); sr_enter_req = 0;
    chk("R8 entry taken", sr_active, 1);
    chk("R8 owed cleared", ref_req, 0);
    repeat (200) @(negedge clk);
    chk("R9 no request in SR", ref_req, 0);
    chk("R9 no urgent in SR", ref_urgent, 0);
    sr_exit_req = 1; @(negedge clk); sr_exit_req = 0;
    chk("R10 exit", sr_active, 0);
    for (int k = 0; k < 39; k++) begin
      if (ref_busy) nb++;
      if (rd_block) nr++;
      if (k == 19) chk("R10 timer restarted, none owed", ref_req, 0);
      if (k == 20) chk("R2 first owed after exit", ref_req, 1);
      @(negedge clk);
    end
    chk("R10 busy length", nb, TXSNR);
    chk("R10 read block length", nr, TXSRD);
    pulse_ack();
    chk("R5 ack on wrap accepted", ref_busy, 1);
    repeat (TRFC) @(negedge clk);
    chk("R5 count unchanged on wrap", ref_req, 1);
    chk("R4 not urgent", ref_urgent, 0);
  endtask

  initial begin
    t_reset();
    t_first_tick();
    t_ack_window();
    t_bad_ack();
    t_urgent_burst();
    t_self_refresh();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule